// File: doc/BRIEF.md
# Seconds-Resolution Watchdog Timer

This block is a watchdog peripheral seen by software through an 8-byte window on a simple 32-bit register bus. Offset 0 holds control and status, offset 4 holds the reload period in whole seconds. A clock prescaler turns the core clock into a one-second tick. Each tick moves a countdown one step towards zero. Software keeps the system alive by setting a self-clearing trigger bit, which reloads the countdown from the period register and restarts the prescaler.

When the countdown reaches zero the block fires exactly once. For a fixed number of clock cycles it drives either a system-reset request or a power-off request, as selected by a control bit. It also sets a sticky flag that survives the ordinary reset input. Only the power-on reset input or a software write clears that flag.

A separate two-bit configuration register gates the unit. One bit enables the timing function. The other opens the register window.

Top module: `sec_wdog`

## Requirements
- R1: While configuration bit 1 (window enable) is 0, writes to the window change nothing and every read of the window returns 0.
- R2: The control word at offset 0 (address bit 2 = 0) exposes run at bit 0 and the action select at bit 2, both as last written. Bit 7 is the trigger, and it always reads 0.
- R3: Writing bit 7 = 1 at offset 0 loads the countdown from the period register and restarts the prescaler. The countdown is readable at offset 4, bits [25:16], on the cycle after the write.
- R4: With run = 1 and configuration bit 0 = 1, the countdown drops by one every TICK_CYC clock cycles, counted from the trigger. With run = 0 it holds.
- R5: The period register sits at offset 4, bits [9:0]. Its reset value is DEF_TMO. A write of 0 is ignored. A write while counting changes only later reloads, never the current count.
- R6: When a tick takes the countdown from 1 to 0, exactly one request pulse of PULSE_CYC cycles follows. It appears on rst_req if bit 2 was 0, or on pwroff_req if bit 2 was 1. The countdown then stays at 0 and the two requests are never high together.
- R7: Control bit 1 (fired) becomes 1 on expiry. Writing 1 to bit 1 or asserting por_n clears it. Asserting rst_n leaves it unchanged.
- R8: While configuration bit 0 is 0, control bit 3 reads 1, the countdown does not move and no request is raised.
- R9: If a trigger falls on the cycle of a one-second tick, the reload wins. The count equals the period and the next step comes a full TICK_CYC cycles later.
- R10: rst_n clears run, the action select, the countdown, the configuration, the prescaler and any request pulse, and restores the period to DEF_TMO. por_n does all of this and also clears fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low, keeps the fired flag |
| por_n | input | 1 | Synchronous power-on reset, active low, clears everything |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 2 | Configuration value: bit 0 function enable, bit 1 window enable |
| bus_sel | input | 1 | Window access select |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Byte offset in the window, bit 2 picks the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rst_req | output | 1 | System-reset request pulse |
| pwroff_req | output | 1 | Power-off request pulse |

## Verification
A software reload and a one-second tick can land on the same clock edge, and so can an expiry and a write that clears the fired flag. The bench times a second trigger to be sampled exactly TICK_CYC cycles after the first. It then reads the countdown to confirm that the reload, not the decrement, took effect (R9). A behavioural model runs beside the design and is compared on every cycle. Its rule is that the reload beats the tick and that expiry beats the clear. Any ordering slip therefore shows up as a mismatch in the read data or the request pins.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;
  localparam int CTL_RUN   = 0;
  localparam int CTL_FIRED = 1;
  localparam int CTL_ACT   = 2;
  localparam int CTL_DIS   = 3;
  localparam int CTL_TRIG  = 7;
  localparam int CFG_FUNC  = 0;
  localparam int CFG_WIN   = 1;
  localparam int CNT_LSB   = 16;

  function automatic logic [31:0] pack_ctl(input logic run, input logic fired,
                                           input logic act, input logic dis);
    logic [31:0] w;
    w = '0;
    w[CTL_RUN]   = run;
    w[CTL_FIRED] = fired;
    w[CTL_ACT]   = act;
    w[CTL_DIS]   = dis;
    return w;
  endfunction

  function automatic logic last_step(input logic tick, input logic [15:0] cnt);
    return tick && (cnt == 16'd1);
  endfunction
endpackage

// File: rtl/sec_wdog_prescale.sv
module sec_wdog_prescale #(
  parameter int TICK_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic tick
);
  localparam int PW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign tick    = active && at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (restart)  pre_q <= '0;
    else if (active)   pre_q <= at_last ? '0 : pre_q + 1'b1;
  end

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
  p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sec_wdog_count.sv
module sec_wdog_count #(
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] load_val,
  input  logic             tick,
  output logic [TMO_W-1:0] cnt,
  output logic             expire
);
  import sec_wdog_pkg::*;

  logic [TMO_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = !load && last_step(tick, 16'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
  p_expire_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/sec_wdog_fire.sv
module sec_wdog_fire #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic act_sel,
  output logic rst_req,
  output logic pwroff_req
);
  localparam int QW = $clog2(PULSE_CYC + 1);

  logic [QW-1:0] left_q;
  logic          sel_q;
  logic          busy;

  assign busy       = (left_q != '0);
  assign rst_req    = busy && !sel_q;
  assign pwroff_req = busy && sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      sel_q  <= 1'b0;
    end else if (expire) begin
      left_q <= QW'(PULSE_CYC);
      sel_q  <= act_sel;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, pwroff_req}));
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req || pwroff_req));
endmodule

// File: rtl/sec_wdog_regs.sv
module sec_wdog_regs #(
  parameter int TMO_W   = 10,
  parameter int DEF_TMO = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wdata,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             expire,
  input  logic [TMO_W-1:0] cnt,
  output logic [31:0]      bus_rdata,
  output logic             run,
  output logic             act,
  output logic             func_en,
  output logic [TMO_W-1:0] tmo,
  output logic             trig
);
  import sec_wdog_pkg::*;

  logic [1:0]       cfg_q;
  logic             run_q, act_q, fired_q;
  logic [TMO_W-1:0] tmo_q;
  logic             win_en, wr, ctl_wr, tmo_wr;

  assign win_en  = cfg_q[CFG_WIN];
  assign func_en = cfg_q[CFG_FUNC];
  assign wr      = bus_sel && bus_we && win_en;
  assign ctl_wr  = wr && !bus_addr[2];
  assign tmo_wr  = wr && bus_addr[2];
  assign trig    = ctl_wr && bus_wdata[CTL_TRIG];
  assign run     = run_q;
  assign act     = act_q;
  assign tmo     = tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
      act_q <= 1'b0;
      tmo_q <= TMO_W'(DEF_TMO);
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (ctl_wr) begin
        run_q <= bus_wdata[CTL_RUN];
        act_q <= bus_wdata[CTL_ACT];
      end
      if (tmo_wr && bus_wdata[TMO_W-1:0] != '0) tmo_q <= bus_wdata[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)                                   fired_q <= 1'b0;
    else if (rst_n && expire)                     fired_q <= 1'b1;
    else if (rst_n && ctl_wr && bus_wdata[CTL_FIRED]) fired_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (win_en) begin
      if (bus_addr[2]) begin
        bus_rdata[TMO_W-1:0]           = tmo_q;
        bus_rdata[CNT_LSB +: TMO_W]    = cnt;
      end else begin
        bus_rdata = pack_ctl(run_q, fired_q, act_q, !func_en);
      end
    end
  end

  p_fired_set_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    expire |=> fired_q);
  p_closed_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !win_en && !cfg_we) |=> ($stable(run_q) && $stable(tmo_q) && $stable(act_q)));
endmodule

// File: rtl/sec_wdog.sv
module sec_wdog #(
  parameter int TICK_CYC  = 50_000_000,
  parameter int TMO_W     = 10,
  parameter int DEF_TMO   = 60,
  parameter int PULSE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_wdata,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req,
  output logic        pwroff_req
);
  logic             rst_all_n;
  logic             run, act, func_en, trig, tick, expire, active;
  logic [TMO_W-1:0] tmo, cnt;

  assign rst_all_n = rst_n && por_n;
  assign active    = run && func_en;

  sec_wdog_regs #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_all_n), .por_n(por_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .expire(expire), .cnt(cnt), .bus_rdata(bus_rdata),
    .run(run), .act(act), .func_en(func_en), .tmo(tmo), .trig(trig)
  );

  sec_wdog_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
    .clk(clk), .rst_n(rst_all_n), .restart(trig), .active(active), .tick(tick)
  );

  sec_wdog_count #(.TMO_W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_all_n), .load(trig), .load_val(tmo), .tick(tick),
    .cnt(cnt), .expire(expire)
  );

  sec_wdog_fire #(.PULSE_CYC(PULSE_CYC)) u_fire (
    .clk(clk), .rst_n(rst_all_n), .expire(expire), .act_sel(act),
    .rst_req(rst_req), .pwroff_req(pwroff_req)
  );

  p_no_req_disabled_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
    !func_en |-> !expire);
endmodule

// File: tb/sec_wdog_tb.sv
module sec_wdog_tb;
  localparam int T = 8;
  localparam int P = 5;
  localparam int DEF = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rst_req, pwroff_req;

  int checks = 0, fails = 0, rst_hi = 0, pwr_hi = 0;
  string cur_req = "R10";
  bit done = 0;

  sec_wdog #(.TICK_CYC(T), .TMO_W(10), .DEF_TMO(DEF), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .pwroff_req(pwroff_req)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_run = 0, m_act = 0, m_fired = 0, m_tmo = DEF, m_cnt = 0, m_phase = 0;
  int m_left = 0, m_psel = 0, m_func = 0, m_win = 0;

  function automatic int model_read(input int addr);
    if (m_win == 0) return 0;
    if (addr & 4) return m_tmo + (m_cnt << 16);
    return m_run + (m_fired << 1) + (m_act << 2) + ((m_func == 0) ? 8 : 0);
  endfunction

  always @(posedge clk) begin
    int w, trg, ex, oact;
    if (!por_n) begin
      m_fired = 0;
    end
    if (!por_n || !rst_n) begin
      m_run = 0; m_act = 0; m_tmo = DEF; m_cnt = 0; m_phase = 0;
      m_left = 0; m_psel = 0; m_func = 0; m_win = 0;
    end else begin
      w = (bus_sel && bus_we && m_win != 0) ? 1 : 0;
      trg = (w != 0 && !bus_addr[2] && bus_wdata[7]) ? 1 : 0;
      ex = 0;
      oact = m_act;
      if (trg != 0) begin
        m_phase = 0; m_cnt = m_tmo;
      end else if (m_run != 0 && m_func != 0) begin
        if (m_phase == T - 1) begin
          m_phase = 0;
          if (m_cnt > 0) begin
            if (m_cnt == 1) ex = 1;
            m_cnt = m_cnt - 1;
          end
        end else m_phase = m_phase + 1;
      end
      if (ex != 0) begin m_left = P; m_psel = oact; end
      else if (m_left > 0) m_left = m_left - 1;
      if (ex != 0) m_fired = 1;
      else if (w != 0 && !bus_addr[2] && bus_wdata[1]) m_fired = 0;
      if (w != 0 && !bus_addr[2]) begin
        m_run = bus_wdata[0]; m_act = bus_wdata[2];
      end
      if (w != 0 && bus_addr[2] && bus_wdata[9:0] != 0) m_tmo = bus_wdata[9:0];
      if (cfg_we) begin m_func = cfg_wdata[0]; m_win = cfg_wdata[1]; end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(posedge clk) begin
    #5;
    if (rst_n && por_n && !done) begin
      check(cur_req, int'(bus_rdata), model_read(int'(bus_addr)));
      check(cur_req, {31'b0, rst_req}, (m_left > 0 && m_psel == 0) ? 1 : 0);
      check(cur_req, {31'b0, pwroff_req}, (m_left > 0 && m_psel != 0) ? 1 : 0);
      if (rst_req) rst_hi++;
      if (pwroff_req) pwr_hi++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    bus_sel = 1; bus_we = 1; bus_addr = 3'(addr); bus_wdata = data;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic cfg(input int v);
    cfg_we = 1; cfg_wdata = 2'(v);
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int addr, output int v);
    bus_addr = 3'(addr); #1; v = int'(bus_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    cur_req = "R10";
    check("R10 reset rdata", int'(bus_rdata), 0);
    check("R10 reset req", {30'b0, rst_req, pwroff_req}, 0);
    por_n = 1; rst_n = 1; @(negedge clk);

    cur_req = "R1";
    wr(4, 5);
    rd(4, v); check("R1 closed read", v, 0);
    cfg(2);
    rd(4, v); check("R1 write ignored / R5 default", v & 16'h3ff, DEF);
    rd(0, v); check("R8 disabled bit", v, 8);

    cur_req = "R5";
    wr(4, 0);
    rd(4, v); check("R5 zero write ignored", v & 16'h3ff, DEF);
    wr(4, 3);
    cfg(3);

    cur_req = "R2";
    rst_hi = 0; pwr_hi = 0;
    wr(0, 32'h81);
    rd(0, v); check("R2 trigger reads 0", v, 1);
    rd(4, v); check("R3 reload", v >> 16, 3);
    cur_req = "R4";
    idle(T);
    rd(4, v); check("R4 one step", v >> 16, 2);
    cur_req = "R6";
    idle(2 * T + P + 4);
    check("R6 reset pulse length", rst_hi, P);
    check("R6 no power-off", pwr_hi, 0);
    rd(4, v); check("R6 count stays 0", v >> 16, 0);
    rd(0, v); check("R7 fired set", v & 2, 2);

    cur_req = "R7";
    rst_n = 0; @(negedge clk); rst_n = 1;
    cfg(3);
    rd(0, v); check("R7 fired survives rst_n / R10 run cleared", v, 2);
    rd(4, v); check("R10 period restored", v, DEF);
    wr(0, 2);
    rd(0, v); check("R7 write-1 clears", v, 0);

    cur_req = "R6";
    rst_hi = 0; pwr_hi = 0;
    wr(4, 2);
    wr(0, 32'h85);
    idle(2 * T + P + 4);
    check("R6 power-off pulse length", pwr_hi, P);
    check("R6 no reset", rst_hi, 0);

    cur_req = "R8";
    cfg(2); rst_hi = 0; pwr_hi = 0;
    wr(0, 32'h81);
    idle(4 * T);
    rd(4, v); check("R8 frozen", v >> 16, 2);
    check("R8 no request", rst_hi + pwr_hi, 0);

    cur_req = "R4";
    cfg(3); wr(4, 4);
    wr(0, 32'h80);
    idle(3 * T);
    rd(4, v); check("R4 run=0 holds", v >> 16, 4);

    cur_req = "R9";
    wr(0, 32'h81);
    idle(T - 1);
    wr(0, 32'h81);
    rd(4, v); check("R9 reload beats tick", v >> 16, 4);
    idle(T - 1);
    rd(4, v); check("R9 no early step", v >> 16, 4);
    idle(1);
    rd(4, v); check("R9 step after full second", v >> 16, 3);

    cur_req = "R5";
    wr(4, 9);
    rd(4, v); check("R5 running count unchanged", v >> 16, 3);
    wr(0, 32'h81);
    rd(4, v); check("R5 new period on reload", v >> 16, 9);

    cur_req = "R7";
    wr(4, 1); wr(0, 32'h81);
    idle(T + P + 2);
    rd(0, v); check("R7 fired before por", v & 2, 2);
    por_n = 0; @(negedge clk); por_n = 1;
    cfg(2);
    rd(0, v); check("R7 por clears fired", v & 2, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule